// File: doc/BRIEF.md
# Compare-Match Timer

An up-counting timer that advances only when a prescaler tick arrives, with two compare channels that each drive an output waveform pin. A control register selects the counting mode and, per channel, the action applied to that channel's output when the counter matches the channel's compare value. In clear-on-match (CTC) mode the counter returns to zero on the tick after it equals channel A's compare value, which gives a programmable period.

Software reaches five registers over a simple write strobe and combinational read bus. Address 0 is control, 1 is the counter, 2 is compare A, 3 is compare B and 4 is the flag register. Control bits: [7:6] channel A action code, [5:4] channel B action code, [3:2] reserved, [1:0] counting mode (00 free running, 10 CTC, 01 and 11 unsupported waveform codes). Flag bits: [0] overflow, [1] match A, [2] match B. Channel index 0 is A and 1 is B on every two-bit port.

Top module: `tcm_timer`

## Requirements
- R1: After reset the counter, compare values, control, flags, compare outputs, overrides and drive enables are all 0.
- R2: A write to address 0 stores bits [7:4] and [1:0]; bits [3:2] always read back as 0 whatever was written. Reads return the addressed register zero-extended, and unused addresses read 0.
- R3: The counter changes only on a tick or a counter write (write wins). In free-running mode a tick increments it, wrapping from all-ones to 0, and that increment from all-ones sets flag bit 0 on the same clock edge.
- R4: In CTC mode (mode 10), a tick while the counter equals compare A loads 0 instead of incrementing, and no overflow flag is raised by that clear.
- R5: A channel's match flag (bit 1 for A, bit 2 for B) sets on the clock edge after a tick has brought the counter to a value equal to that channel's compare register.
- R6: On that same edge, in mode 00 or 10, the channel's output follows its action code: 00 no change, 01 invert, 10 drive 0, 11 drive 1.
- R7: A channel's override output is 1 whenever its action code is nonzero, and its drive enable is its override ANDed with its external direction enable input.
- R8: Writing 1 to a flag bit at address 4 clears it and writing 0 leaves it; a flag set in the same cycle as its clear stays set.
- R9: After a counter write no match is taken for the written value, so neither a flag nor an output action follows until a tick moves the counter.
- R10: With mode 01 or 11 the compare outputs hold their value on a match, while flags and counting behave as in free-running mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| dir_en_i | input | 2 | External pin direction enables, per channel |
| cnt_o | output | CNT_W | Counter value |
| flags_o | output | 3 | Match B, match A, overflow flags |
| oc_o | output | 2 | Compare output waveform per channel |
| ovr_o | output | 2 | Compare output replaces port control |
| drv_en_o | output | 2 | Pin driver enable per channel |

## Verification
The bench builds the timer with its default 8-bit counter, so a wrap from 255 to 0 and the matching overflow flag are reached within a few hundred ticks of the random run. Compare values are often drawn small, which makes CTC periods short and lets both channels' match actions recur many times per thousand cycles. Two tick patterns are used, random ticks and one tick every eight clocks, and counter writes are sometimes aimed at a compare value to reach the match-blocking case.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned NCH    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hF3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_PWM1 = 2'b01,
    MODE_CTC  = 2'b10,
    MODE_PWM3 = 2'b11
  } mode_e;
endpackage

// File: rtl/tcm_regs.sv
module tcm_regs
  import tcm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o,
  output logic              wr_cnt_o,
  output logic [NFLAG-1:0]  flag_clr_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q  <= wdata_i[CTRL_W-1:0] & CTRL_WMASK;
        A_CMPA:  cmp_a_q <= wdata_i;
        A_CMPB:  cmp_b_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_a_o    = cmp_a_q;
  assign cmp_b_o    = cmp_b_q;
  assign wr_cnt_o   = wr_en_i && (addr_i == A_CNT);
  assign flag_clr_o = (wr_en_i && (addr_i == A_FLAGS)) ? wdata_i[NFLAG-1:0] : '0;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[3:2] == 2'b00);
endmodule

// File: rtl/tcm_counter.sv
module tcm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctc_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             upd_q, ovf_q, at_top, ovf_set;

  assign at_top  = ctc_i && (cnt_q == top_i);
  assign ovf_set = tick_i && !wr_i && !at_top && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      upd_q <= tick_i && !wr_i;  // a loaded value never matches
      ovf_q <= (ovf_q && !ovf_clr_i) || ovf_set;
      if (wr_i)        cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
  assign ovf_o = ovf_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  // R4
  ctc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && ctc_i && cnt_q == top_i) |=> (cnt_q == '0 && !$rose(ovf_q)));
  // R9
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !upd_q);
endmodule

// File: rtl/tcm_channel.sv
module tcm_channel
  import tcm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       code_i,
  input  logic             act_en_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             oc_o
);
  logic flag_q, oc_q, match;

  assign match = upd_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      flag_q <= (flag_q && !clr_i) || match;
      if (match && act_en_i) begin
        case (act_e'(code_i))
          ACT_TOG: oc_q <= !oc_q;
          ACT_CLR: oc_q <= 1'b0;
          ACT_SET: oc_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign flag_o = flag_q;
  assign oc_o   = oc_q;

  // R5
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(upd_i && cnt_i == cmp_i));
  // R6
  set_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && cnt_i == cmp_i && act_en_i && code_i == 2'b11) |=> oc_q);
  // R10
  hold_unsup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en_i |=> $stable(oc_q));
endmodule

// File: rtl/tcm_timer.sv
module tcm_timer
  import tcm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              tick_i,
  input  logic [1:0]        dir_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [2:0]        flags_o,
  output logic [1:0]        oc_o,
  output logic [1:0]        ovr_o,
  output logic [1:0]        drv_en_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cmp_a, cmp_b, cnt;
  logic [CNT_W-1:0]  cmp [NCH];
  logic              wr_cnt, upd, ovf, ctc, act_en;
  logic [NFLAG-1:0]  flag_clr, flags;

  tcm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b),
    .wr_cnt_o(wr_cnt), .flag_clr_o(flag_clr)
  );

  assign ctc    = mode_e'(ctrl[1:0]) == MODE_CTC;
  assign act_en = !ctrl[0];

  tcm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .ctc_i(ctc), .top_i(cmp_a),
    .wr_i(wr_cnt), .wdata_i, .ovf_clr_i(flag_clr[0]),
    .cnt_o(cnt), .upd_o(upd), .ovf_o(ovf)
  );

  assign cmp[0]   = cmp_a;
  assign cmp[1]   = cmp_b;
  assign flags[0] = ovf;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] code;
    assign code = ctrl[7-2*c -: 2];
    tcm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .upd_i(upd), .cnt_i(cnt), .cmp_i(cmp[c]),
      .code_i(code), .act_en_i(act_en), .clr_i(flag_clr[c+1]),
      .flag_o(flags[c+1]), .oc_o(oc_o[c])
    );
    assign ovr_o[c]    = |code;
    assign drv_en_o[c] = ovr_o[c] && dir_en_i[c];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl;
      A_CNT:   rdata_o = cnt;
      A_CMPA:  rdata_o = cmp_a;
      A_CMPB:  rdata_o = cmp_b;
      A_FLAGS: rdata_o[NFLAG-1:0] = flags;
      default: ;
    endcase
  end

  assign cnt_o   = cnt;
  assign flags_o = flags;

  // R7
  drv_needs_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o & ~ovr_o) == 2'b00);
  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr == '0) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/tcm_timer_bench.sv
module tcm_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int RAND_CYC = 20000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic             tick = 1'b0;
  logic [1:0]       dir_en = '0;
  logic [CNT_W-1:0] rdata, cnt;
  logic [2:0]       flags;
  logic [1:0]       oc, ovr, drv;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcm_timer #(.CNT_W(CNT_W)) u_tcm_timer (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .dir_en_i(dir_en), .cnt_o(cnt),
    .flags_o(flags), .oc_o(oc), .ovr_o(ovr), .drv_en_o(drv)
  );

  // reference model built from the requirements
  logic [7:0]       m_ctrl;
  logic [CNT_W-1:0] m_cnt, m_cmp_a, m_cmp_b;
  logic [2:0]       m_flags;
  logic [1:0]       m_oc;
  logic             m_upd;

  function automatic logic [1:0] apply_act(logic [1:0] code, logic cur);
    case (code)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] model_read(logic [2:0] a);
    case (a)
      3'd0:    return CNT_W'(m_ctrl);
      3'd1:    return m_cnt;
      3'd2:    return m_cmp_a;
      3'd3:    return m_cmp_b;
      3'd4:    return CNT_W'(m_flags);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl <= '0; m_cnt <= '0; m_cmp_a <= '0; m_cmp_b <= '0;
      m_flags <= '0; m_oc <= '0; m_upd <= 1'b0;
    end else begin
      logic wc, ma, mb, sup, ctc_top, ovf;
      logic [2:0] clr;
      wc  = wr_en && addr == 3'd1;
      ma  = m_upd && m_cnt == m_cmp_a;
      mb  = m_upd && m_cnt == m_cmp_b;
      sup = (m_ctrl[1:0] == 2'b00) || (m_ctrl[1:0] == 2'b10);
      ctc_top = (m_ctrl[1:0] == 2'b10) && m_cnt == m_cmp_a;
      ovf = tick && !wc && !ctc_top && (m_cnt == '1);
      clr = (wr_en && addr == 3'd4) ? wdata[2:0] : 3'b000;
      m_flags <= (m_flags & ~clr) | {mb, ma, ovf};
      m_upd   <= tick && !wc;
      if (wc) m_cnt <= wdata;
      else if (tick) m_cnt <= ctc_top ? '0 : m_cnt + 1'b1;
      if (ma && sup) m_oc[0] <= apply_act(m_ctrl[7:6], m_oc[0]);
      if (mb && sup) m_oc[1] <= apply_act(m_ctrl[5:4], m_oc[1]);
      if (wr_en && addr == 3'd0) m_ctrl <= wdata[7:0] & 8'hF3;
      if (wr_en && addr == 3'd2) m_cmp_a <= wdata;
      if (wr_en && addr == 3'd3) m_cmp_b <= wdata;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [1:0] m_ovr;
    m_ovr = {|m_ctrl[5:4], |m_ctrl[7:6]};
    chk("R3", "cnt", int'(cnt), int'(m_cnt));
    chk("R5", "flags", int'(flags), int'(m_flags));
    chk("R6", "oc", int'(oc), int'(m_oc));
    chk("R7", "ovr", int'(ovr), int'(m_ovr));
    chk("R7", "drv", int'(drv), int'(m_ovr & dir_en));
    chk("R2", "rdata", int'(rdata), int'(model_read(addr)));
  endtask

  task automatic cyc(logic w, logic [2:0] a, logic [CNT_W-1:0] d, logic t);
    wr_en = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic idle(logic [2:0] a);
    cyc(1'b0, a, '0, 1'b0);
  endtask

  task automatic tk();
    cyc(1'b0, 3'd4, '0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pre;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "cnt", int'(cnt), 0);
    chk("R1", "flags", int'(flags), 0);
    chk("R1", "oc/ovr/drv", int'({oc, ovr, drv}), 0);
    chk("R1", "ctrl read", int'(rdata), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 reserved bits, R7 override and drive enable
    dir_en = 2'b01;
    wr(3'd0, 8'hFF);
    idle(3'd0);
    chk("R2", "ctrl read", int'(rdata), 8'hF3);
    chk("R7", "ovr", int'(ovr), 3);
    chk("R7", "drv", int'(drv), 1);
    idle(3'd6);
    chk("R2", "unused read", int'(rdata), 0);

    // CTC, A toggle, B clear
    wr(3'd0, 8'h62);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'd0);
    tk();
    idle(3'd4);
    chk("R5", "flag B", int'(flags[2]), 1);
    chk("R5", "flag A early", int'(flags[1]), 0);
    tk(); tk();
    chk("R4", "cnt at top", int'(cnt), 3);
    idle(3'd4);
    chk("R5", "flag A", int'(flags[1]), 1);
    chk("R6", "oc A toggled", int'(oc[0]), 1);
    tk();
    chk("R4", "cnt cleared", int'(cnt), 0);
    chk("R4", "no ovf", int'(flags[0]), 0);

    // R8 clear with write-one
    wr(3'd4, 8'h04);
    chk("R8", "only B cleared", int'(flags), 2);
    wr(3'd4, 8'h07);
    chk("R8", "all cleared", int'(flags), 0);

    // R9 loaded value does not match
    wr(3'd1, 8'd3);
    idle(3'd4); idle(3'd4);
    chk("R9", "no flag A", int'(flags[1]), 0);
    chk("R9", "oc A held", int'(oc[0]), 1);

    // R10 unsupported mode holds outputs
    wr(3'd0, 8'h41);
    wr(3'd1, 8'd2);
    tk();
    idle(3'd4);
    chk("R10", "flag A", int'(flags[1]), 1);
    chk("R10", "oc A held", int'(oc[0]), 1);
    wr(3'd4, 8'h07);

    // R3 wrap in free-running mode
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd254);
    tk(); tk();
    chk("R3", "wrap", int'(cnt), 0);
    chk("R3", "ovf", int'(flags[0]), 1);
    idle(3'd1);
    chk("R3", "held", int'(cnt), 0);

    // random phase: random ticks, then one tick per 8 clocks
    pre = 0;
    for (int i = 0; i < RAND_CYC; i++) begin
      logic t, w;
      logic [2:0] a;
      logic [CNT_W-1:0] d;
      if (i < RAND_CYC/2) t = ($urandom % 3) == 0;
      else begin
        t = (pre == 7);
        pre = (pre + 1) % 8;
      end
      w = ($urandom % 100) < 6;
      a = 3'($urandom % 6);
      d = CNT_W'($urandom);
      if (a == 3'd0 && ($urandom % 2)) d[1:0] = 2'b10;
      if ((a == 3'd2 || a == 3'd3) && ($urandom % 2)) d = CNT_W'($urandom % 16);
      if (a == 3'd1 && ($urandom % 3) == 0) d = ($urandom % 2) ? m_cmp_a : m_cmp_b;
      if (($urandom % 64) == 0) dir_en = 2'($urandom);
      cyc(w, a, d, t);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule